// File: doc/BRIEF.md
# Immediate-Format Integer Execute Unit

This block executes the integer instructions of one 32-bit encoding that carries a 16-bit constant, a source register index and a destination register index. It holds a bank of sixteen 32-bit data registers, a bank of sixteen 32-bit address registers, and a register of arithmetic status flags. Each valid instruction is decoded and computed in a single cycle. The result is written to the selected bank on the next rising clock edge.

The one constant field is used in four ways. It can be sign-extended, zero-extended, placed in the upper half-word, or used as a control-register offset. For a control-register read or write, the block sends the offset to a separate control-register port. A read writes the returned word into a data register. A write sends out the content of a data register. A writeback bus shows each register write as it happens. Opcodes that the block does not recognise raise an illegal-instruction output and change no state.

Top module: `imm_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers and all five status flags. While `instr_valid` is low, `illegal`, `wb_en`, `cr_rd_en` and `cr_wr_en` stay low.
- R2: The instruction fields are opcode in bits 7:0, source index in bits 11:8, constant in bits 27:12 and destination index in bits 31:28. Opcode 0x1B writes data[src] plus the sign-extended constant to data[dst].
- R3: Opcodes 0x1B and 0x9B update the `flags` output. Bit 0 is the carry out of the 32-bit add. Bit 1 is signed overflow. Bit 3 is result bit 31 XOR result bit 30.
- R4: Flag bit 2 latches bit 1, and flag bit 4 latches bit 3. Once set, they stay set until reset.
- R5: Opcode 0x9B writes data[src] plus (constant << 16) to data[dst].
- R6: Opcode 0x11 writes addr[src] plus (constant << 16) to addr[dst] and leaves the flags unchanged.
- R7: Opcode 0x3B writes the sign-extended constant to data[dst]. Opcode 0xBB writes the zero-extended constant.
- R8: Opcode 0x7B writes (constant << 16) to data[dst]. Opcode 0x91 writes the same value to addr[dst].
- R9: Opcode 0x4D raises `cr_rd_en`, drives the constant on `cr_addr`, and writes `cr_rdata` into data[dst].
- R10: Opcode 0xCD raises `cr_wr_en`, drives the constant on `cr_addr` and data[dst] on `cr_wdata`. It writes no register and leaves the flags unchanged.
- R11: Any other opcode with `instr_valid` high raises `illegal`, suppresses every register write and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| illegal | output | 1 | Unrecognised opcode this cycle |
| wb_en | output | 1 | A register is written at the coming edge |
| wb_to_addr | output | 1 | Write targets the address bank (else the data bank) |
| wb_idx | output | 4 | Register index being written |
| wb_data | output | 32 | Value being written |
| flags | output | 5 | {sticky adv-ovf, adv-ovf, sticky ovf, ovf, carry} |
| cr_rd_en | output | 1 | Control-register read request |
| cr_wr_en | output | 1 | Control-register write request |
| cr_addr | output | 16 | Control-register offset |
| cr_wdata | output | 32 | Data for a control-register write |
| cr_rdata | input | 32 | Data returned for a control-register read |

## Verification
The constant 0xFFFE is applied as a signed move, an unsigned move and, through an add, as a carry source. This tells sign extension apart from zero extension. The upper-half forms are driven with values that cross bit 30 and bit 31. These separate advance overflow from signed overflow and carry. A later add with none of these conditions confirms that only the sticky bits remain set. Register contents are read back through control-register writes and address adds of zero. These readbacks show that the writes went to the right bank, and that illegal or non-valid words left every register and flag as it was.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int IDXW   = $clog2(NREG);
    localparam int CONSTW = 16;
    localparam int OPW    = 8;
    localparam int HALF   = XLEN / 2;

    localparam logic [OPW-1:0] OPC_ADD_IMM    = 8'h1B;
    localparam logic [OPW-1:0] OPC_ADD_HI     = 8'h9B;
    localparam logic [OPW-1:0] OPC_ADD_HI_A   = 8'h11;
    localparam logic [OPW-1:0] OPC_MOV_S      = 8'h3B;
    localparam logic [OPW-1:0] OPC_MOV_Z      = 8'hBB;
    localparam logic [OPW-1:0] OPC_MOV_HI     = 8'h7B;
    localparam logic [OPW-1:0] OPC_MOV_HI_A   = 8'h91;
    localparam logic [OPW-1:0] OPC_CR_READ    = 8'h4D;
    localparam logic [OPW-1:0] OPC_CR_WRITE   = 8'hCD;

    typedef enum logic [3:0] {
        K_NONE, K_ADD_IMM, K_ADD_HI, K_ADD_HI_A, K_MOV_S, K_MOV_Z,
        K_MOV_HI, K_MOV_HI_A, K_CR_READ, K_CR_WRITE, K_BAD
    } kind_e;

    typedef struct packed {
        logic [IDXW-1:0]   dst;
        logic [CONSTW-1:0] imm;
        logic [IDXW-1:0]   src;
        logic [OPW-1:0]    opc;
    } ifields_t;

    typedef struct packed {
        logic sav;
        logic av;
        logic sv;
        logic v;
        logic c;
    } flags_t;

    function automatic kind_e classify(input logic [OPW-1:0] opc);
        case (opc)
            OPC_ADD_IMM:  return K_ADD_IMM;
            OPC_ADD_HI:   return K_ADD_HI;
            OPC_ADD_HI_A: return K_ADD_HI_A;
            OPC_MOV_S:    return K_MOV_S;
            OPC_MOV_Z:    return K_MOV_Z;
            OPC_MOV_HI:   return K_MOV_HI;
            OPC_MOV_HI_A: return K_MOV_HI_A;
            OPC_CR_READ:  return K_CR_READ;
            OPC_CR_WRITE: return K_CR_WRITE;
            default:      return K_BAD;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [CONSTW-1:0] k);
        return {{(XLEN-CONSTW){k[CONSTW-1]}}, k};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [CONSTW-1:0] k);
        return {{(XLEN-CONSTW){1'b0}}, k};
    endfunction

    function automatic logic [XLEN-1:0] high_imm(input logic [CONSTW-1:0] k);
        return {k, {(XLEN-CONSTW){1'b0}}};
    endfunction
endpackage

// File: rtl/imm_decode.sv
module imm_decode
    import imm_exec_pkg::*;
(
    input  logic            valid,
    input  logic [XLEN-1:0] word,
    output ifields_t        fld,
    output kind_e           kind
);
    always_comb begin
        fld  = ifields_t'(word);
        kind = valid ? classify(fld.opc) : K_NONE;
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int N   = 16,
    parameter int W   = 32,
    parameter int NRD = 1,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IW-1:0]          wr_idx,
    input  logic [W-1:0]           wr_data,
    input  logic [NRD-1:0][IW-1:0] rd_idx,
    output logic [NRD-1:0][W-1:0]  rd_data
);
    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_idx[p]];
    end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
    import imm_exec_pkg::*;
(
    input  kind_e             kind,
    input  logic [CONSTW-1:0] imm,
    input  logic [XLEN-1:0]   d_src,
    input  logic [XLEN-1:0]   a_src,
    input  logic [XLEN-1:0]   cr_rdata,
    input  flags_t            flg_q,
    output logic [XLEN-1:0]   res,
    output logic              wr_d,
    output logic              wr_a,
    output flags_t            flg_d
);
    logic [XLEN-1:0] addend;
    logic [XLEN:0]   sum;
    logic            arith;

    always_comb begin
        addend = (kind == K_ADD_IMM) ? sext_imm(imm) : high_imm(imm);
        sum    = {1'b0, d_src} + {1'b0, addend};
        arith  = (kind == K_ADD_IMM) || (kind == K_ADD_HI);
        res    = '0;
        wr_d   = 1'b0;
        wr_a   = 1'b0;
        case (kind)
            K_ADD_IMM, K_ADD_HI: begin res = sum[XLEN-1:0];            wr_d = 1'b1; end
            K_ADD_HI_A:          begin res = a_src + high_imm(imm);    wr_a = 1'b1; end
            K_MOV_S:             begin res = sext_imm(imm);            wr_d = 1'b1; end
            K_MOV_Z:             begin res = zext_imm(imm);            wr_d = 1'b1; end
            K_MOV_HI:            begin res = high_imm(imm);            wr_d = 1'b1; end
            K_MOV_HI_A:          begin res = high_imm(imm);            wr_a = 1'b1; end
            K_CR_READ:           begin res = cr_rdata;                 wr_d = 1'b1; end
            default:             begin res = '0; end
        endcase
        flg_d = flg_q;
        if (arith) begin
            flg_d.c   = sum[XLEN];
            flg_d.v   = (d_src[XLEN-1] == addend[XLEN-1]) &&
                        (sum[XLEN-1] != d_src[XLEN-1]);
            flg_d.av  = sum[XLEN-1] ^ sum[XLEN-2];
            flg_d.sv  = flg_q.sv  | flg_d.v;
            flg_d.sav = flg_q.sav | flg_d.av;
        end
    end
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
    import imm_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr,
    output logic              illegal,
    output logic              wb_en,
    output logic              wb_to_addr,
    output logic [IDXW-1:0]   wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic [4:0]        flags,
    output logic              cr_rd_en,
    output logic              cr_wr_en,
    output logic [CONSTW-1:0] cr_addr,
    output logic [XLEN-1:0]   cr_wdata,
    input  logic [XLEN-1:0]   cr_rdata
);
    ifields_t               fld;
    kind_e                  kind;
    logic [1:0][XLEN-1:0]   d_rd;
    logic [0:0][XLEN-1:0]   a_rd;
    logic [XLEN-1:0]        res;
    logic                   wr_d, wr_a;
    flags_t                 flg_q, flg_d;

    imm_decode u_dec (
        .valid(instr_valid), .word(instr), .fld(fld), .kind(kind)
    );

    reg_bank #(.N(NREG), .W(XLEN), .NRD(2)) u_dbank (
        .clk(clk), .rst(rst), .we(wr_d), .wr_idx(fld.dst), .wr_data(res),
        .rd_idx({fld.dst, fld.src}), .rd_data(d_rd)
    );

    reg_bank #(.N(NREG), .W(XLEN), .NRD(1)) u_abank (
        .clk(clk), .rst(rst), .we(wr_a), .wr_idx(fld.dst), .wr_data(res),
        .rd_idx(fld.src), .rd_data(a_rd)
    );

    imm_alu u_alu (
        .kind(kind), .imm(fld.imm), .d_src(d_rd[0]), .a_src(a_rd[0]),
        .cr_rdata(cr_rdata), .flg_q(flg_q), .res(res),
        .wr_d(wr_d), .wr_a(wr_a), .flg_d(flg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '0;
        else     flg_q <= flg_d;
    end

    assign illegal    = (kind == K_BAD);
    assign wb_en      = wr_d | wr_a;
    assign wb_to_addr = wr_a;
    assign wb_idx     = fld.dst;
    assign wb_data    = res;
    assign flags      = flg_q;
    assign cr_rd_en   = (kind == K_CR_READ);
    assign cr_wr_en   = (kind == K_CR_WRITE);
    assign cr_addr    = fld.imm;
    assign cr_wdata   = d_rd[1];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !(illegal || wb_en || cr_rd_en || cr_wr_en)); // R1
    AST_STICKY_SV: assert property (@(posedge clk) disable iff (rst)
        flags[2] |=> flags[2]); // R4
    AST_STICKY_SAV: assert property (@(posedge clk) disable iff (rst)
        flags[4] |=> flags[4]); // R4
    AST_ADDR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_to_addr) |=> $stable(flags)); // R6
    AST_CRWR_NO_WB: assert property (@(posedge clk) disable iff (rst)
        cr_wr_en |-> (!wb_en && !cr_rd_en)); // R10
    AST_CRWR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        cr_wr_en |=> $stable(flags)); // R10
    AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(wb_en || cr_rd_en || cr_wr_en)); // R11
    AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(flags)); // R11
endmodule

// File: tb/imm_exec_unit_tb.sv
module imm_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        illegal, wb_en, wb_to_addr, cr_rd_en, cr_wr_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data, cr_wdata;
    logic [31:0] cr_rdata = '0;
    logic [4:0]  flags;
    logic [15:0] cr_addr;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    imm_exec_unit u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .illegal(illegal), .wb_en(wb_en), .wb_to_addr(wb_to_addr),
        .wb_idx(wb_idx), .wb_data(wb_data), .flags(flags),
        .cr_rd_en(cr_rd_en), .cr_wr_en(cr_wr_en), .cr_addr(cr_addr),
        .cr_wdata(cr_wdata), .cr_rdata(cr_rdata)
    );

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [3:0] s,
                                       input logic [15:0] k, input logic [3:0] d);
        return {d, k, s, op};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr = w;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
    endtask

    task automatic read_d(input logic [3:0] n, output logic [31:0] v);
        issue(mk(8'hCD, 4'd0, 16'h0000, n));
        v = cr_wdata;
    endtask

    task automatic read_a(input logic [3:0] n, output logic [31:0] v);
        issue(mk(8'h11, n, 16'h0000, n));
        v = wb_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        idle();
        check("R1 flags", {27'd0, flags}, 32'd0);
        check("R1 idle strobes", {28'd0, illegal, wb_en, cr_rd_en, cr_wr_en}, 32'd0);
        read_d(4'd5, v);
        check("R1 data reg", v, 32'd0);
        read_a(4'd9, v);
        check("R1 addr reg", v, 32'd0);
    endtask

    task automatic t_moves();
        logic [31:0] v;
        issue(mk(8'h3B, 4'd0, 16'hFFFE, 4'd1));
        check("R7 mov signed wb", wb_data, 32'hFFFFFFFE);
        issue(mk(8'hBB, 4'd0, 16'hFFFE, 4'd2));
        check("R7 mov unsigned wb", wb_data, 32'h0000FFFE);
        issue(mk(8'h7B, 4'd0, 16'h1234, 4'd3));
        check("R8 mov high wb", {wb_data[31:1], wb_to_addr}, {31'h091A0000, 1'b0});
        issue(mk(8'h91, 4'd0, 16'hABCD, 4'd4));
        check("R8 mov high addr bank", {31'd0, wb_to_addr}, 32'd1);
        idle();
        check("R7 moves keep flags", {27'd0, flags}, 32'd0);
        read_d(4'd1, v); check("R7 d1", v, 32'hFFFFFFFE);
        read_d(4'd2, v); check("R7 d2", v, 32'h0000FFFE);
        read_d(4'd3, v); check("R8 d3", v, 32'h12340000);
        read_a(4'd4, v); check("R8 a4", v, 32'hABCD0000);
        read_d(4'd4, v); check("R8 d4 untouched", v, 32'd0);
    endtask

    task automatic t_adds();
        logic [31:0] v;
        issue(mk(8'h1B, 4'd1, 16'h0003, 4'd5));
        check("R2 add imm wb", wb_data, 32'h00000001);
        idle();
        check("R3 carry only", {27'd0, flags}, 32'h01);
        issue(mk(8'h9B, 4'd3, 16'h6000, 4'd6));
        check("R5 add high wb", wb_data, 32'h72340000);
        idle();
        check("R3 adv ovf", {27'd0, flags}, 32'h18);
        issue(mk(8'h7B, 4'd0, 16'h7FFF, 4'd8));
        issue(mk(8'h9B, 4'd8, 16'h0001, 4'd9));
        idle();
        check("R3 signed ovf", {27'd0, flags}, 32'h1E);
        read_d(4'd9, v); check("R5 d9", v, 32'h80000000);
        issue(mk(8'h1B, 4'd0, 16'h0001, 4'd10));
        idle();
        check("R4 sticky remain", {27'd0, flags}, 32'h14);
        issue(mk(8'h11, 4'd4, 16'h0001, 4'd5));
        check("R6 addr add wb", wb_data, 32'hABCE0000);
        idle();
        check("R6 flags unchanged", {27'd0, flags}, 32'h14);
        read_a(4'd5, v); check("R6 a5", v, 32'hABCE0000);
        read_d(4'd5, v); check("R6 d5 untouched", v, 32'h00000001);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        cr_rdata = 32'hCAFEF00D;
        issue(mk(8'h4D, 4'd0, 16'hFE04, 4'd11));
        check("R9 cr read strobe", {15'd0, cr_rd_en, cr_addr}, {15'd0, 1'b1, 16'hFE04});
        check("R9 cr read wb", {27'd0, wb_en, wb_idx}, {27'd0, 1'b1, 4'd11});
        idle();
        cr_rdata = '0;
        issue(mk(8'hCD, 4'd0, 16'h0010, 4'd11));
        check("R10 cr write data", cr_wdata, 32'hCAFEF00D);
        check("R10 cr write strobes", {14'd0, cr_wr_en, wb_en, cr_addr},
              {14'd0, 1'b1, 1'b0, 16'h0010});
        idle();
        check("R10 flags unchanged", {27'd0, flags}, 32'h14);
        read_d(4'd11, v); check("R9 d11", v, 32'hCAFEF00D);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        issue(mk(8'h00, 4'd0, 16'h0005, 4'd1));
        check("R11 illegal", {30'd0, illegal, wb_en}, 32'h2);
        issue(mk(8'h1C, 4'd3, 16'h0005, 4'd1));
        check("R11 illegal near opcode", {30'd0, illegal, wb_en}, 32'h2);
        idle();
        check("R11 flags unchanged", {27'd0, flags}, 32'h14);
        read_d(4'd1, v); check("R11 d1 kept", v, 32'hFFFFFFFE);
        @(negedge clk);
        instr_valid = 1'b0;
        instr = mk(8'h3B, 4'd0, 16'h0042, 4'd1);
        #1;
        check("R1 no valid quiet", {28'd0, illegal, wb_en, cr_rd_en, cr_wr_en}, 32'd0);
        idle();
        read_d(4'd1, v); check("R1 no valid kept d1", v, 32'hFFFFFFFE);
    endtask

    task automatic t_rereset();
        logic [31:0] v;
        @(negedge clk);
        instr_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R4 sticky cleared by reset", {27'd0, flags}, 32'd0);
        read_d(4'd11, v); check("R1 reset clears d11", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_moves();
        t_adds();
        t_ctrl();
        t_illegal();
        t_rereset();
        idle();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule